// File: doc/BRIEF.md
# Nine-Bit Multidrop Serial Transceiver

This block is a full-duplex asynchronous serial transceiver. It sends and receives two frame shapes. The short frame has ten bits: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The long frame has eleven bits and adds a ninth bit before the stop bit. The transmitter starts a frame as soon as a byte is loaded. The ninth bit it sends is taken from a control input. The receiver watches the line for a falling edge. It then takes sixteen samples per bit and decides each bit by a vote over the three samples at the middle of the bit.

On a shared multidrop line, the receiver can filter frames. When the filter input is set, a frame is kept only if its ninth bit is 1. In the short frame the stop bit is used as the ninth bit. A frame is also refused while the previous one is still unacknowledged. A refused frame is dropped without any trace. The bit rate comes either from a fixed divider of the clock or from an overflow tick supplied from outside. A doubling input selects between two rates in both cases.

Top module: `mpu_uart`

## Requirements
- R1: After reset, `txd` is 1, `tx_done` and `rx_done` are 0, and `rx_byte` and `rx_bit9` are 0.
- R2: A one-cycle `tx_load` starts a frame. `txd` goes low in the next cycle for the start bit. Then come the eight bits of `tx_data`, least significant first. If `mode[1]`=1, `tx_bit9` follows. Last comes a high stop bit. Each bit lasts sixteen sample periods.
- R3: `tx_done` goes to 1 at the end of the stop bit. It stays at 1 until `clr_tx_done` is pulsed.
- R4: The sample period depends on `mode[0]` and `dbl`. With `mode[0]`=0 it is FIX_DIV clocks when `dbl`=1 and 2·FIX_DIV clocks when `dbl`=0. With `mode[0]`=1 it is one `ovf_tick` when `dbl`=1 and two `ovf_tick`s when `dbl`=0. A frame of N bits therefore lasts 16·N sample periods.
- R5: A falling edge on `rxd` starts reception only while `rx_en`=1. A frame sent while `rx_en`=0 leaves `rx_done` and `rx_byte` unchanged.
- R6: Each received bit takes the majority value of samples 7, 8 and 9, counted from 0 within the bit. A one-clock inversion inside a bit does not change the received value.
- R7: If a start bit reads high at its vote point, reception aborts without setting any flag. The receiver then waits for a new falling edge.
- R8: A frame is accepted only if `rx_done` is 0 and either `mp_filt`=0 or the received ninth bit is 1. In the short frame (`mode[1]`=0) the stop bit plays the part of the ninth bit.
- R9: When a frame is accepted, `rx_byte` receives the data byte, `rx_bit9` receives the ninth bit (or the stop bit in the short frame), and `rx_done` goes to 1. When a frame is refused, all three outputs stay as they were.
- R10: A frame that ends while `rx_done`=1 is dropped. The earlier `rx_byte` is kept.
- R11: The transmitter and the receiver work independently. A frame can be received while another frame is being sent.
- R12: The receiver completes its decision at the vote point of the stop bit. A start bit that directly follows a stop bit of full length is therefore caught.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Bit 1: frame has a ninth bit; bit 0: rate from `ovf_tick` instead of the fixed divider |
| tx_bit9 | input | 1 | Ninth bit sent in long frames |
| rx_en | input | 1 | Allows reception to start |
| mp_filt | input | 1 | Multidrop filter: keep only frames whose ninth bit is 1 |
| dbl | input | 1 | Rate doubling |
| ovf_tick | input | 1 | External rate tick, one clock wide |
| tx_load | input | 1 | Load strobe for `tx_data`; starts a frame |
| tx_data | input | 8 | Byte to send |
| clr_tx_done | input | 1 | Clears `tx_done` |
| clr_rx_done | input | 1 | Clears `rx_done` |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line |
| rx_byte | output | 8 | Last accepted data byte |
| rx_bit9 | output | 1 | Ninth bit (or stop bit) of the last accepted frame |
| tx_done | output | 1 | Frame sent |
| rx_done | output | 1 | Frame accepted |

## Verification
The bench builds the block with OSR=16, SYNC=2 and FIX_DIV=1. With these values the fast fixed rate takes one sample every clock, so a bit lasts exactly sixteen clocks. This makes it cheap to send all 256 byte values through a loopback in long frames. The bench also sends a spread of values in short frames and measures the length of each frame in clocks for every rate source, computing the expected count from 16·N·P. Because a bench-driven bit lasts exactly sixteen clocks, single-clock noise, glitches that are shorter than half a bit, and back-to-back frames can all be placed precisely.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
   // bit positions inside the mode select
   localparam int MODE_TICK_BIT = 0;
   localparam int MODE_NINE_BIT = 1;
   // bit counts of the two frame shapes
   localparam int FRAME_SHORT = 10;
   localparam int FRAME_LONG  = 11;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction
endpackage

// File: rtl/mpu_baud.sv
module mpu_baud #(
   parameter int FIX_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic use_tick,
   input  logic dbl,
   input  logic ovf_tick,
   output logic smp
);
   localparam int LIM_FAST = FIX_DIV - 1;
   localparam int LIM_SLOW = 2 * FIX_DIV - 1;
   localparam int PW       = (LIM_SLOW < 1) ? 1 : $clog2(LIM_SLOW + 1);

   logic [PW-1:0] pre_q;
   logic [PW-1:0] lim;
   logic          half_q;
   logic          fix_hit;
   logic          tick_hit;

   assign lim      = dbl ? PW'(LIM_FAST) : PW'(LIM_SLOW);
   assign fix_hit  = (pre_q >= lim);
   assign tick_hit = ovf_tick & (dbl | half_q);
   assign smp      = use_tick ? tick_hit : fix_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         half_q <= 1'b0;
      end else begin
         if (use_tick || fix_hit) pre_q <= '0;
         else                     pre_q <= pre_q + 1'b1;
         if (use_tick && ovf_tick) half_q <= ~half_q;
      end
   end

   // R4
   fix_slow_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp && !use_tick && !dbl && $past(!use_tick && !dbl)) |-> !$past(smp));

   // R4
   tick_slow_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (use_tick && !dbl && $past(use_tick && !dbl && smp)) |-> !smp);
endmodule

// File: rtl/mpu_tx.sv
module mpu_tx
   import mpu_pkg::*;
#(
   parameter int OSR = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       smp,
   input  logic       nine,
   input  logic       bit9,
   input  logic       load,
   input  logic [7:0] data,
   input  logic       clr_done,
   output logic       txd,
   output logic       done
);
   localparam int SW = $clog2(OSR);
   localparam int FW = FRAME_LONG;
   localparam int CW = $clog2(FW + 1);

   logic [FW-1:0] sh_q;
   logic [CW-1:0] left_q;
   logic [SW-1:0] sub_q;
   logic          done_q;
   logic          busy;
   logic          bit_end;
   logic          last_end;

   assign busy     = (left_q != '0);
   assign bit_end  = busy && smp && (sub_q == SW'(OSR - 1));
   assign last_end = bit_end && (left_q == CW'(1));
   assign txd      = sh_q[0];
   assign done     = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '1;
         left_q <= '0;
         sub_q  <= '0;
      end else if (load) begin
         sh_q   <= {1'b1, (nine ? bit9 : 1'b1), data, 1'b0};
         left_q <= nine ? CW'(FRAME_LONG) : CW'(FRAME_SHORT);
         sub_q  <= '0;
      end else if (busy && smp) begin
         if (bit_end) begin
            sub_q  <= '0;
            sh_q   <= {1'b1, sh_q[FW-1:1]};
            left_q <= left_q - 1'b1;
         end else begin
            sub_q <= sub_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  done_q <= 1'b0;
      else if (last_end && !load)  done_q <= 1'b1;
      else if (clr_done)           done_q <= 1'b0;
   end

   // R2
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load) |-> !txd);

   // R2
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   // R3
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !clr_done) |=> done_q);

   // R3
   done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> (!busy && txd));
endmodule

// File: rtl/mpu_rx.sv
module mpu_rx
   import mpu_pkg::*;
#(
   parameter int OSR  = 16,
   parameter int SYNC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       smp,
   input  logic       nine,
   input  logic       en,
   input  logic       filt,
   input  logic       rxd,
   input  logic       clr_done,
   output logic [7:0] rx_byte,
   output logic       rx_bit9,
   output logic       done
);
   localparam int SW  = $clog2(OSR);
   localparam int VLO = OSR / 2 - 1;
   localparam int VHI = OSR / 2 + 1;

   logic [SYNC-1:0] sy_q;
   logic            line;
   logic            prev_q;
   logic            active_q;
   logic            nine_f_q;
   logic [3:0]      idx_q;
   logic [SW-1:0]   sub_q;
   logic [1:0]      v_q;
   logic [7:0]      sh_q;
   logic            b9_q;
   logic [7:0]      byte_q;
   logic            bit9_q;
   logic            done_q;
   logic            at_vote;
   logic            bitv;
   logic            is_last;
   logic            flag;
   logic            start_bad;
   logic            accept;

   generate
      if (SYNC == 1) begin : g_sync_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sy_q <= '1;
            else        sy_q <= rxd;
         end
      end else begin : g_sync_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sy_q <= '1;
            else        sy_q <= {sy_q[SYNC-2:0], rxd};
         end
      end
   endgenerate

   assign line      = sy_q[SYNC-1];
   assign at_vote   = active_q && smp && (sub_q == SW'(VHI));
   assign bitv      = maj3(v_q[0], v_q[1], line);
   assign is_last   = (idx_q == (nine_f_q ? 4'd10 : 4'd9));
   assign flag      = nine_f_q ? b9_q : bitv;
   assign start_bad = at_vote && (idx_q == 4'd0) && bitv;
   assign accept    = at_vote && is_last && !done_q && (!filt || flag);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= 1'b1;
         active_q <= 1'b0;
         nine_f_q <= 1'b0;
         idx_q    <= '0;
         sub_q    <= '0;
         v_q      <= '0;
         sh_q     <= '0;
         b9_q     <= 1'b0;
      end else begin
         prev_q <= line;
         if (!active_q) begin
            if (en && prev_q && !line) begin
               active_q <= 1'b1;
               idx_q    <= '0;
               sub_q    <= '0;
               nine_f_q <= nine;
            end
         end else if (smp) begin
            if (sub_q == SW'(VLO))     v_q[0] <= line;
            if (sub_q == SW'(VLO + 1)) v_q[1] <= line;
            if (at_vote) begin
               if (idx_q >= 4'd1 && idx_q <= 4'd8) sh_q <= {bitv, sh_q[7:1]};
               if (idx_q == 4'd9 && nine_f_q)      b9_q <= bitv;
               if (start_bad || is_last)           active_q <= 1'b0;
            end
            if (sub_q == SW'(OSR - 1)) begin
               sub_q <= '0;
               idx_q <= idx_q + 1'b1;
            end else begin
               sub_q <= sub_q + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_q <= '0;
         bit9_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         if (accept) begin
            byte_q <= sh_q;
            bit9_q <= flag;
            done_q <= 1'b1;
         end else if (clr_done) begin
            done_q <= 1'b0;
         end
      end
   end

   assign rx_byte = byte_q;
   assign rx_bit9 = bit9_q;
   assign done    = done_q;

   // R8
   accept_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> (!$past(filt) || bit9_q));

   // R10
   held_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !clr_done) |=> ($stable(byte_q) && $stable(bit9_q)));

   // R5
   enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && !en) |=> !active_q);
endmodule

// File: rtl/mpu_uart.sv
module mpu_uart
   import mpu_pkg::*;
#(
   parameter int OSR     = 16,
   parameter int FIX_DIV = 2,
   parameter int SYNC    = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       tx_bit9,
   input  logic       rx_en,
   input  logic       mp_filt,
   input  logic       dbl,
   input  logic       ovf_tick,
   input  logic       tx_load,
   input  logic [7:0] tx_data,
   input  logic       clr_tx_done,
   input  logic       clr_rx_done,
   input  logic       rxd,
   output logic       txd,
   output logic [7:0] rx_byte,
   output logic       rx_bit9,
   output logic       tx_done,
   output logic       rx_done
);
   generate
      if (OSR < 8 || (OSR % 2) != 0) begin : g_bad_osr
         $error("mpu_uart: OSR must be even and at least 8");
      end
      if (FIX_DIV < 1) begin : g_bad_div
         $error("mpu_uart: FIX_DIV must be at least 1");
      end
      if (SYNC < 1) begin : g_bad_sync
         $error("mpu_uart: SYNC must be at least 1");
      end
   endgenerate

   logic smp;
   logic nine_sel;
   logic tick_sel;

   assign nine_sel = mode[MODE_NINE_BIT];
   assign tick_sel = mode[MODE_TICK_BIT];

   mpu_baud #(.FIX_DIV(FIX_DIV)) u_baud (
      .clk      (clk),
      .rst_n    (rst_n),
      .use_tick (tick_sel),
      .dbl      (dbl),
      .ovf_tick (ovf_tick),
      .smp      (smp)
   );

   mpu_tx #(.OSR(OSR)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp      (smp),
      .nine     (nine_sel),
      .bit9     (tx_bit9),
      .load     (tx_load),
      .data     (tx_data),
      .clr_done (clr_tx_done),
      .txd      (txd),
      .done     (tx_done)
   );

   mpu_rx #(.OSR(OSR), .SYNC(SYNC)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp      (smp),
      .nine     (nine_sel),
      .en       (rx_en),
      .filt     (mp_filt),
      .rxd      (rxd),
      .clr_done (clr_rx_done),
      .rx_byte  (rx_byte),
      .rx_bit9  (rx_bit9),
      .done     (rx_done)
   );
endmodule

// File: tb/tb_mpu_uart.sv
module tb_mpu_uart;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] mode;
   logic       tx_bit9, rx_en, mp_filt, dbl, ovf_tick;
   logic       tx_load, clr_tx_done, clr_rx_done;
   logic [7:0] tx_data;
   logic       rxd, txd, rx_bit9, tx_done, rx_done;
   logic [7:0] rx_byte;
   logic       loop_en, line;
   int         n_chk = 0;
   int         n_bad = 0;
   int         tdiv  = 3;
   int         tcnt  = 0;

   always #2 clk = ~clk;

   assign rxd = loop_en ? txd : line;

   mpu_uart #(.OSR(16), .FIX_DIV(1), .SYNC(2)) dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .tx_bit9(tx_bit9), .rx_en(rx_en),
      .mp_filt(mp_filt), .dbl(dbl), .ovf_tick(ovf_tick), .tx_load(tx_load),
      .tx_data(tx_data), .clr_tx_done(clr_tx_done), .clr_rx_done(clr_rx_done),
      .rxd(rxd), .txd(txd), .rx_byte(rx_byte), .rx_bit9(rx_bit9),
      .tx_done(tx_done), .rx_done(rx_done)
   );

   always @(negedge clk) begin
      if (tcnt >= tdiv - 1) tcnt = 0;
      else                  tcnt = tcnt + 1;
      ovf_tick = (tcnt == 0);
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clr_both();
      @(negedge clk); clr_tx_done = 1'b1; clr_rx_done = 1'b1;
      @(negedge clk); clr_tx_done = 1'b0; clr_rx_done = 1'b0;
   endtask

   // sends one byte; decodes txd at mid-bit and measures frame length (P = clocks per sample)
   task automatic send_tx(input logic [7:0] v, input logic b9, input int p, input logic nine,
                          input string req);
      logic [10:0] exp, got;
      int nb, el, lo, hi, target;
      nb  = nine ? 11 : 10;
      exp = '0;
      exp[8:1] = v;
      if (nine) begin exp[9] = b9; exp[10] = 1'b1; end
      else      exp[9] = 1'b1;
      got = '0;
      @(negedge clk); tx_data = v; tx_bit9 = b9; tx_load = 1'b1;
      @(negedge clk); tx_load = 1'b0;
      el = 0;
      for (int k = 0; k < nb; k++) begin
         target = p * (16 * k + 8);
         cyc(target - el);
         el = target;
         got[k] = txd;
      end
      check(req, {21'd0, got}, {21'd0, exp});
      lo = 16 * nb * p - p + 1;
      hi = 16 * nb * p;
      while (!tx_done && el < hi + 4) begin cyc(1); el++; end
      check("R3 tx_done set", {31'd0, tx_done}, 32'd1);
      check("R4 frame length in range", {31'd0, (el >= lo && el <= hi)}, 32'd1);
   endtask

   task automatic drive_rx(input logic [7:0] v, input logic b9, input logic stopv,
                           input logic nine, input logic noisy);
      line = 1'b0; cyc(16);
      for (int i = 0; i < 8; i++) begin
         line = v[i];
         if (noisy) begin
            cyc(8); line = ~v[i]; cyc(1); line = v[i]; cyc(7);
         end else cyc(16);
      end
      if (nine) begin line = b9; cyc(16); end
      line = stopv; cyc(16);
      line = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; mode = 2'b10; tx_bit9 = 0; rx_en = 0; mp_filt = 0; dbl = 1;
      tx_load = 0; tx_data = 0; clr_tx_done = 0; clr_rx_done = 0;
      loop_en = 0; line = 1'b1; ovf_tick = 0;
      cyc(5);
      // R1 reset state
      check("R1 txd", {31'd0, txd}, 32'd1);
      check("R1 tx_done", {31'd0, tx_done}, 32'd0);
      check("R1 rx_done", {31'd0, rx_done}, 32'd0);
      check("R1 rx_byte", {24'd0, rx_byte}, 32'd0);
      check("R1 rx_bit9", {31'd0, rx_bit9}, 32'd0);
      rst_n = 1'b1;
      cyc(3);

      // R2 R9 full byte sweep, long frames, loopback, fast fixed rate
      loop_en = 1; rx_en = 1;
      for (int v = 0; v < 256; v++) begin
         send_tx(8'(v), ^8'(v), 1, 1'b1, "R2 long frame bits");
         cyc(1);
         check("R9 rx_done", {31'd0, rx_done}, 32'd1);
         check("R9 rx_byte", {24'd0, rx_byte}, v);
         check("R9 rx_bit9", {31'd0, rx_bit9}, {31'd0, ^8'(v)});
         if (v % 32 == 0) begin
            cyc(20);
            check("R3 tx_done holds", {31'd0, tx_done}, 32'd1);
         end
         clr_both();
         check("R3 tx_done cleared", {31'd0, tx_done}, 32'd0);
      end

      // R2 short frames, stop bit reported as ninth bit
      mode = 2'b00;
      for (int i = 0; i < 32; i++) begin
         send_tx(8'(i * 8 + 3), 1'b0, 1, 1'b0, "R2 short frame bits");
         cyc(1);
         check("R9 short rx_byte", {24'd0, rx_byte}, i * 8 + 3);
         check("R9 short rx_bit9 is stop", {31'd0, rx_bit9}, 32'd1);
         clr_both();
      end

      // R4 rate sources
      mode = 2'b10; dbl = 0;
      for (int i = 0; i < 3; i++) begin
         send_tx(8'(8'h5C + i), 1'b1, 2, 1'b1, "R4 fixed slow bits");
         cyc(1); check("R4 fixed slow rx", {24'd0, rx_byte}, 8'h5C + i); clr_both();
      end
      mode = 2'b11; dbl = 1;
      for (int i = 0; i < 3; i++) begin
         send_tx(8'(8'h91 + i), 1'b0, 3, 1'b1, "R4 tick fast bits");
         cyc(1); check("R4 tick fast rx", {24'd0, rx_byte}, 8'h91 + i); clr_both();
      end
      dbl = 0;
      for (int i = 0; i < 2; i++) begin
         send_tx(8'(8'h2D + i), 1'b1, 6, 1'b1, "R4 tick slow bits");
         cyc(1); check("R4 tick slow rx", {24'd0, rx_byte}, 8'h2D + i); clr_both();
      end
      mode = 2'b01; dbl = 1;
      send_tx(8'hE7, 1'b0, 3, 1'b0, "R4 short tick bits");
      cyc(1); check("R4 short tick rx", {24'd0, rx_byte}, 8'hE7); clr_both();

      // direct receive tests, bench drives 16-clock bits
      loop_en = 0; mode = 2'b10; dbl = 1; cyc(4);
      // R6 majority vote against one-clock noise
      drive_rx(8'hA5, 1'b1, 1'b1, 1'b1, 1'b1); cyc(2);
      check("R6 noisy A5", {24'd0, rx_byte}, 32'hA5); clr_both();
      drive_rx(8'h00, 1'b0, 1'b1, 1'b1, 1'b1); cyc(2);
      check("R6 noisy 00", {24'd0, rx_byte}, 32'h00); clr_both();
      drive_rx(8'hFF, 1'b0, 1'b1, 1'b1, 1'b1); cyc(2);
      check("R6 noisy FF", {24'd0, rx_byte}, 32'hFF); clr_both();

      // R7 short low glitch aborts
      line = 1'b0; cyc(4); line = 1'b1; cyc(60);
      check("R7 glitch no flag", {31'd0, rx_done}, 32'd0);
      check("R7 glitch byte kept", {24'd0, rx_byte}, 32'hFF);
      drive_rx(8'h3C, 1'b0, 1'b1, 1'b1, 1'b0); cyc(2);
      check("R7 frame after glitch", {24'd0, rx_byte}, 32'h3C); clr_both();

      // R5 receive enable
      rx_en = 0;
      drive_rx(8'h11, 1'b1, 1'b1, 1'b1, 1'b0); cyc(20);
      check("R5 disabled no flag", {31'd0, rx_done}, 32'd0);
      check("R5 disabled byte kept", {24'd0, rx_byte}, 32'h3C);
      rx_en = 1; cyc(2);
      drive_rx(8'h22, 1'b1, 1'b1, 1'b1, 1'b0); cyc(2);
      check("R5 enabled accepted", {24'd0, rx_byte}, 32'h22); clr_both();

      // R8 filter, long frames
      mp_filt = 1;
      drive_rx(8'h44, 1'b0, 1'b1, 1'b1, 1'b0); cyc(20);
      check("R8 filtered no flag", {31'd0, rx_done}, 32'd0);
      check("R9 refused byte kept", {24'd0, rx_byte}, 32'h22);
      drive_rx(8'h55, 1'b1, 1'b1, 1'b1, 1'b0); cyc(2);
      check("R8 ninth set accepted", {24'd0, rx_byte}, 32'h55);
      check("R8 rx_bit9", {31'd0, rx_bit9}, 32'd1); clr_both();
      // R8 filter, short frames use stop bit
      mode = 2'b00; cyc(2);
      drive_rx(8'h66, 1'b0, 1'b0, 1'b0, 1'b0); cyc(20);
      check("R8 short low stop refused", {31'd0, rx_done}, 32'd0);
      check("R8 short refused byte kept", {24'd0, rx_byte}, 32'h55);
      drive_rx(8'h77, 1'b0, 1'b1, 1'b0, 1'b0); cyc(2);
      check("R8 short high stop accepted", {24'd0, rx_byte}, 32'h77); clr_both();
      mp_filt = 0;
      drive_rx(8'h88, 1'b0, 1'b0, 1'b0, 1'b0); cyc(20);
      check("R8 unfiltered low stop accepted", {24'd0, rx_byte}, 32'h88);
      check("R8 low stop in rx_bit9", {31'd0, rx_bit9}, 32'd0); clr_both();

      // R10 overrun keeps earlier byte
      mode = 2'b10; cyc(4);
      drive_rx(8'h99, 1'b1, 1'b1, 1'b1, 1'b0); cyc(2);
      drive_rx(8'hAA, 1'b0, 1'b1, 1'b1, 1'b0); cyc(2);
      check("R10 flag still set", {31'd0, rx_done}, 32'd1);
      check("R10 earlier byte kept", {24'd0, rx_byte}, 32'h99);
      check("R10 earlier bit9 kept", {31'd0, rx_bit9}, 32'd1);
      clr_both();

      // R12 back-to-back frames
      fork
         begin
            drive_rx(8'h5A, 1'b1, 1'b1, 1'b1, 1'b0);
            drive_rx(8'hC3, 1'b0, 1'b1, 1'b1, 1'b0);
         end
         begin
            while (!rx_done) cyc(1);
            check("R12 first frame", {24'd0, rx_byte}, 32'h5A);
            @(negedge clk); clr_rx_done = 1'b1;
            @(negedge clk); clr_rx_done = 1'b0;
         end
      join
      cyc(2);
      check("R12 second frame", {24'd0, rx_byte}, 32'hC3);
      check("R12 second bit9", {31'd0, rx_bit9}, 32'd0);
      clr_both();

      // R11 full duplex
      fork
         send_tx(8'h3E, 1'b1, 1, 1'b1, "R11 tx while receiving");
         drive_rx(8'hB7, 1'b0, 1'b1, 1'b1, 1'b0);
      join
      cyc(2);
      check("R11 rx while sending", {24'd0, rx_byte}, 32'hB7);
      check("R11 rx_done", {31'd0, rx_done}, 32'd1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule